// File: doc/BRIEF.md
# Bi-Quinary Decade Counter

This block is a four-bit counter built from two sections that can run apart or be chained. The first section is a single toggling stage that drives Q0 from its own count input. The second is a binary divide-by-five that counts 0 to 4 on Q1 to Q3 from a second count input. Both count inputs advance their section on a falling edge. Each input is brought into the system clock domain by a synchronizer, and a falling-edge detector then turns each edge into a one-cycle count event.

A two-bit mode selector sets how the sections are chained. In split mode they work on their own. In decade mode the falling edge of Q0 drives the divide-by-five section, so the outputs give a BCD count 0 to 9 and Q3 runs at one tenth of the input rate. In symmetric mode the wrap of the divide-by-five section drives the toggle stage, so Q0 is a square wave with equal high and low times at one tenth of the rate. A chained count event is formed in the same system cycle as the falling transition that causes it. Two gated controls act on the system clock edge: a two-input preset to nine and a two-input clear to zero. The preset wins over the clear.

Top module: `bq_decade_counter`

## Requirements
- R1: In mode 0 (split), each falling edge on count_a_i inverts q_o[0].
- R2: In mode 0, each falling edge on count_b_i steps q_o[3:1] through 0,1,2,3,4 and then back to 0.
- R3: In mode 1 (decade), falling edges on count_a_i step q_o through the BCD values 0 to 9 and then back to 0. The divide-by-five section steps in the same cycle in which q_o[0] goes from 1 to 0.
- R4: In mode 2 (symmetric), falling edges on count_b_i step the value {q_o[0], q_o[3], q_o[2], q_o[1]} through 0,1,2,3,4,8,9,A,B,C and back to 0. Over one full cycle, q_o[0] is high for 5 of the 10 states.
- R5: Mode value 3 behaves like mode 0. In mode 1, count_b_i has no effect. In mode 2, count_a_i has no effect.
- R6: While preset_a_i and preset_b_i are both high, q_o becomes 4'b1001 at the next clock edge and stays there. Count edges during that time are discarded. Either preset input alone has no effect.
- R7: When both preset inputs and both clear inputs are high, q_o is 4'b1001.
- R8: While clear_a_i and clear_b_i are both high, q_o becomes 0 at the next clock edge and stays there. Either clear input alone has no effect.
- R9: After reset, q_o is 0. A falling edge on a count input, with each level held for at least one clock, changes q_o at the third rising clock edge after the low level is first sampled. Rising edges do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Chaining mode: 0 split, 1 decade, 2 symmetric, 3 split |
| count_a_i | input | 1 | Count input of the toggle section, falling edge active |
| count_b_i | input | 1 | Count input of the divide-by-five section, falling edge active |
| preset_a_i | input | 1 | Preset-to-nine gate input A |
| preset_b_i | input | 1 | Preset-to-nine gate input B |
| clear_a_i | input | 1 | Clear-to-zero gate input A |
| clear_b_i | input | 1 | Clear-to-zero gate input B |
| q_o | output | 4 | Counter outputs Q3..Q0 |

## Verification
A count edge driven between clock edges reaches q_o at the third rising edge after it is first sampled: two synchronizer stages, then the counter register. A chained step adds no further cycle. The preset and clear controls take effect at the very next rising edge. The bench holds a behavioural model that applies these delays to its own record of the sampled inputs, and it compares q_o with that model at every falling clock edge, where all outputs have settled. Direct checks sample at these same points: they confirm that the output is unchanged after one and two edges and has changed after the third.

// File: rtl/bqd_pkg.sv
package bqd_pkg;
  typedef enum logic [1:0] {
    CHAIN_SPLIT     = 2'd0,
    CHAIN_DECADE    = 2'd1,
    CHAIN_SYMMETRIC = 2'd2,
    CHAIN_SPLIT_ALT = 2'd3
  } chain_mode_e;
endpackage

// File: rtl/bqd_fall_detect.sv
module bqd_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic fall_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign fall_o = chain_q[LAST] & ~chain_q[LAST-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R9
endmodule

// File: rtl/bqd_toggle_stage.sv
module bqd_toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic at_high_o
);
  logic q_q;
  logic q_d;
  logic en;

  always_comb begin
    en  = step_i | set_i | clr_i;
    q_d = q_q;
    if (set_i)       q_d = 1'b1;
    else if (clr_i)  q_d = 1'b0;
    else if (step_i) q_d = ~q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= 1'b0;
    else if (en) q_q <= q_d;
  end

  assign q_o       = q_q;
  assign at_high_o = q_q;

  AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !set_i && !clr_i) |=> (q_q != $past(q_q))); // R1
  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !set_i && !clr_i) |=> $stable(q_q)); // R9
endmodule

// File: rtl/bqd_quinary_stage.sv
module bqd_quinary_stage #(
  parameter int WIDTH   = 3,
  parameter int MODULUS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] val_o,
  output logic             at_last_o
);
  localparam logic [WIDTH-1:0] LAST_VAL = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] val_q;
  logic [WIDTH-1:0] val_d;
  logic             en;

  always_comb begin
    en    = step_i | set_i | clr_i;
    val_d = val_q;
    if (set_i)            val_d = LAST_VAL;
    else if (clr_i)       val_d = '0;
    else if (step_i) begin
      if (val_q >= LAST_VAL) val_d = '0;
      else                   val_d = val_q + WIDTH'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= '0;
    else if (en) val_q <= val_d;
  end

  assign val_o     = val_q;
  assign at_last_o = (val_q == LAST_VAL);

  AST_QUINARY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    val_q <= LAST_VAL); // R2
  AST_QUINARY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !set_i && !clr_i) |=>
      (val_q == (($past(val_q) == LAST_VAL) ? '0 : $past(val_q) + WIDTH'(1)))); // R2
endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       count_a_i,
  input  logic       count_b_i,
  input  logic       preset_a_i,
  input  logic       preset_b_i,
  input  logic       clear_a_i,
  input  logic       clear_b_i,
  output logic [3:0] q_o
);
  import bqd_pkg::*;

  localparam int QW = 3;

  chain_mode_e mode;
  logic        fall_a;
  logic        fall_b;
  logic        force_nine;
  logic        force_zero;
  logic        step_a;
  logic        step_b;
  logic        q0;
  logic        q0_high;
  logic [QW-1:0] qv;
  logic        qv_last;

  assign mode = chain_mode_e'(mode_i);

  bqd_fall_detect #(.STAGES(SYNC_STAGES)) u_det_a (
    .clk(clk), .rst_n(rst_n), .din_i(count_a_i), .fall_o(fall_a));
  bqd_fall_detect #(.STAGES(SYNC_STAGES)) u_det_b (
    .clk(clk), .rst_n(rst_n), .din_i(count_b_i), .fall_o(fall_b));

  always_comb begin
    force_nine = preset_a_i & preset_b_i;
    force_zero = clear_a_i & clear_b_i & ~force_nine;
    step_a     = fall_a;
    step_b     = fall_b;
    unique case (mode)
      CHAIN_DECADE:    step_b = fall_a & q0_high;
      CHAIN_SYMMETRIC: step_a = fall_b & qv_last;
      default: ;
    endcase
  end

  bqd_toggle_stage u_div2 (
    .clk(clk), .rst_n(rst_n), .step_i(step_a), .set_i(force_nine),
    .clr_i(force_zero), .q_o(q0), .at_high_o(q0_high));

  bqd_quinary_stage #(.WIDTH(QW), .MODULUS(5)) u_div5 (
    .clk(clk), .rst_n(rst_n), .step_i(step_b), .set_i(force_nine),
    .clr_i(force_zero), .val_o(qv), .at_last_o(qv_last));

  assign q_o = {qv, q0};

  AST_PRESET_NINE: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_a_i && preset_b_i) |=> (q_o == 4'b1001)); // R6
  AST_PRESET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_a_i && preset_b_i && clear_a_i && clear_b_i) |=> (q_o == 4'b1001)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_a_i && clear_b_i && !(preset_a_i && preset_b_i)) |=> (q_o == 4'b0000)); // R8
  AST_DECADE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd1) && fall_a && q0 && !(preset_a_i && preset_b_i)
      && !(clear_a_i && clear_b_i)) |=> (q_o[3:1] != $past(q_o[3:1]))); // R3
  AST_SYM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd2) && fall_b && (q_o[3:1] == 3'd4) && !(preset_a_i && preset_b_i)
      && !(clear_a_i && clear_b_i)) |=> (q_o[0] != $past(q_o[0]))); // R4
  AST_DECADE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1) |-> (q_o <= 4'd9)); // R3
endmodule

// File: tb/test_bq_decade_counter.sv
`timescale 1ns/1ps
module test_bq_decade_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       cnt_a, cnt_b, pre_a, pre_b, clr_a, clr_b;
  logic [3:0] q;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R9";
  bit    done   = 0;

  int m0, m5;
  bit ha[3];
  bit hb[3];

  always #4 clk = ~clk;

  bq_decade_counter i_bq_decade_counter (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .count_a_i(cnt_a), .count_b_i(cnt_b),
    .preset_a_i(pre_a), .preset_b_i(pre_b), .clear_a_i(clr_a), .clear_b_i(clr_b),
    .q_o(q));

  // behavioural reference: two sampled-history steps, then the counter update
  always @(posedge clk) begin
    if (!rst_n) begin
      m0 = 0; m5 = 0;
      ha = '{0, 0, 0}; hb = '{0, 0, 0};
    end else begin
      bit ea, eb;
      ea = ha[2] && !ha[1];
      eb = hb[2] && !hb[1];
      if (pre_a && pre_b) begin
        m0 = 1; m5 = 4;
      end else if (clr_a && clr_b) begin
        m0 = 0; m5 = 0;
      end else begin
        if (mode == 2'd1) eb = ea && (m0 == 1);
        if (mode == 2'd2) ea = eb && (m5 == 4);
        if (ea) m0 = 1 - m0;
        if (eb) m5 = (m5 + 1) % 5;
      end
      ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = cnt_a;
      hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = cnt_b;
    end
  end

  task automatic chk(input string r, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) chk(phase, q, 4'(m5 * 2 + m0));
  end

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_a = 1'b0; repeat (2) @(negedge clk);
      cnt_a = 1'b1; repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_b(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_b = 1'b0; repeat (2) @(negedge clk);
      cnt_b = 1'b1; repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0;
    cnt_a = 1'b1; cnt_b = 1'b1;
    pre_a = 1'b0; pre_b = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset", q, 4'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 latency: change at third rising edge after first sample
    phase = "R9";
    cnt_a = 1'b0;
    @(negedge clk); chk("R9 edge1", q, 4'h0);
    @(negedge clk); chk("R9 edge2", q, 4'h0);
    @(negedge clk); chk("R9 edge3", q, 4'h1);
    cnt_a = 1'b1;
    repeat (4) @(negedge clk); chk("R9 rise", q, 4'h1);

    phase = "R1";
    pulse_a(2); chk("R1 split toggle", q, 4'h1);
    phase = "R2";
    pulse_b(7); chk("R2 split quinary", q, 4'h5);

    phase = "R5";
    mode = 2'd3;
    pulse_a(1); pulse_b(1); chk("R5 mode3 split", q, 4'h6);

    phase = "R8";
    clr_a = 1'b1; repeat (2) @(negedge clk); chk("R8 single clear", q, 4'h6);
    clr_b = 1'b1; @(negedge clk); chk("R8 clear", q, 4'h0);
    pulse_a(1); chk("R8 held", q, 4'h0);
    clr_a = 1'b0; clr_b = 1'b0;

    phase = "R3";
    mode = 2'd1;
    repeat (3) @(negedge clk);
    pulse_a(9); chk("R3 decade nine", q, 4'h9);
    pulse_a(1); chk("R3 decade wrap", q, 4'h0);
    pulse_a(3); chk("R3 decade three", q, 4'h3);
    phase = "R5";
    pulse_b(2); chk("R5 b ignored in decade", q, 4'h3);

    phase = "R8";
    clr_a = 1'b1; clr_b = 1'b1; @(negedge clk);
    clr_a = 1'b0; clr_b = 1'b0;
    phase = "R4";
    mode = 2'd2;
    repeat (2) @(negedge clk);
    begin
      int highs = 0;
      for (int k = 1; k <= 10; k++) begin
        logic [3:0] want;
        pulse_b(1);
        want = (k % 10 < 5) ? 4'(k % 10) : 4'(k % 10 + 3);
        chk("R4 symmetric seq", {q[0], q[3:1]}, want);
        if (q[0]) highs++;
      end
      chk("R4 duty", 4'(highs), 4'd5);
    end
    phase = "R5";
    pulse_b(6);
    pulse_a(3); chk("R5 a ignored in symmetric", {q[0], q[3:1]}, 4'h9);

    phase = "R6";
    pre_a = 1'b1; repeat (2) @(negedge clk);
    pre_a = 1'b0; pre_b = 1'b1; repeat (2) @(negedge clk);
    chk("R6 single preset", {q[0], q[3:1]}, 4'h9);
    pre_b = 1'b0;
    pulse_b(1);
    mode = 2'd0;
    pre_a = 1'b1; pre_b = 1'b1; @(negedge clk); chk("R6 preset", q, 4'h9);
    pulse_a(1); pulse_b(1); chk("R6 held", q, 4'h9);

    phase = "R7";
    clr_a = 1'b1; clr_b = 1'b1; repeat (2) @(negedge clk);
    chk("R7 preset wins", q, 4'h9);
    pre_a = 1'b0; @(negedge clk); chk("R7 clear after release", q, 4'h0);
    clr_a = 1'b0; clr_b = 1'b0; pre_b = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule